// File: doc/BRIEF.md
# Triangular-Filter Threshold Trigger

This block takes one unsigned ADC sample per clock and shapes it with a pair of delay lines. The newest k samples are summed, and the k samples before them are subtracted. The running difference forms a triangle for a step or pulse at the input. A flat input gives zero, because any constant level appears with equal weight in both halves of the window. The shaped value is compared against a threshold that a host writes through a simple register port. When the shaped value crosses the threshold from below, the channel's trigger output goes high for a fixed number of cycles.

The window length k is an input that is held steady while the block runs and is changed only under reset. Values of 0 are treated as 1, and values above the maximum are treated as the maximum. The threshold has full accumulator resolution, so a threshold of zero fires on a shaped value of 1. This lets very small pulses start a readout. The shaped value is also brought out as a monitor output.

Top module: `tri_trigger`

## Requirements
- R1: After the clock edge that accepts sample x[n], filterOut equals the sum of x[n..n-k+1] minus the sum of x[n-k..n-2k+1]. Samples before reset count as 0 and filterOut is a two's-complement value.
- R2: Once the last 2k accepted samples are all equal, whatever their value, filterOut is 0.
- R3: trigOut goes high on the clock edge after the one at which filterOut first exceeds the threshold (strictly greater, signed compare) while the block is armed.
- R4: A trigger pulse lasts exactly PULSE_LEN (default 4) clock cycles.
- R5: After firing, the block stays disarmed until filterOut has been at or below the threshold at a clock edge. A shaped value that stays above the threshold never fires twice. A new crossing during a pulse restarts the pulse count.
- R6: A write with thrWrEn high loads thrWrData at that clock edge, and the new value is used for compares from the next edge. The threshold resets to all ones, so no trigger fires before a write.
- R7: With the threshold at 0, a single sample of value 1 fires the trigger.
- R8: With full-scale input 16383 held at k = MAX_K, filterOut reaches exactly MAX_K*16383 without wrapping.
- R9: While rstN is low, filterOut is 0, trigOut is 0, the delay history is cleared and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | SAMPLE_W | Unsigned ADC sample |
| kSel | input | K_W | Window length k, 1..MAX_K, held stable between resets |
| thrWrEn | input | 1 | Threshold register write strobe |
| thrWrData | input | THR_W | Threshold value to load |
| filterOut | output | ACC_W | Signed shaped value (monitor) |
| trigOut | output | 1 | Per-channel trigger pulse |

## Verification
The properties assume that kSel stays within 1..MAX_K and does not change between resets. The bounds and the flat-input zero both depend on the window in use. The magnitude bound also depends on samples being unsigned values below 2^SAMPLE_W. The stimulus sets kSel only while reset is held and drives sampleIn only with in-range 14-bit values. It changes the threshold only through the write port, so every property works from a history that starts at the reset.

// File: rtl/tri_trigger_pkg.sv
package tri_trigger_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic thrLoad;
  } trigCtl_t;
endpackage

// File: rtl/tri_filt_dp.sv
module tri_filt_dp
  import tri_trigger_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int MAX_K    = 64,
  parameter int K_W      = 7,
  parameter int ACC_W    = 22,
  parameter int THR_W    = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SAMPLE_W-1:0]     sampleIn,
  input  logic [K_W-1:0]          kSel,
  input  logic [THR_W-1:0]        thrWrData,
  input  trigCtl_t                ctl,
  output logic signed [ACC_W-1:0] filtY,
  output logic [THR_W-1:0]        thrVal,
  output logic                    aboveThr
);
  localparam int DLY_D = 2 * MAX_K;
  localparam int DIX_W = (DLY_D > 2) ? $clog2(DLY_D) : 1;

  logic [SAMPLE_W-1:0] dly [DLY_D];
  logic [K_W-1:0]      kEff;
  logic [DIX_W-1:0]    nearIdx, farIdx;
  logic signed [ACC_W-1:0] xNow, xNear, xFar, delta;

  // clamp window length to 1..MAX_K
  always_comb begin
    if (kSel == '0)                 kEff = K_W'(1);
    else if (kSel > K_W'(MAX_K))    kEff = K_W'(MAX_K);
    else                            kEff = kSel;
  end

  assign nearIdx = DIX_W'(kEff - K_W'(1));
  assign farIdx  = DIX_W'({kEff, 1'b0} - (K_W+1)'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DLY_D; i++) dly[i] <= '0;
    end else begin
      dly[0] <= sampleIn;
      for (int i = 1; i < DLY_D; i++) dly[i] <= dly[i-1];
    end
  end

  always_comb begin
    xNow  = signed'(ACC_W'(sampleIn));
    xNear = signed'(ACC_W'(dly[nearIdx]));
    xFar  = signed'(ACC_W'(dly[farIdx]));
    delta = xNow - (xNear <<< 1) + xFar;
  end

  always_ff @(posedge clk) begin
    if (!rstN) filtY <= '0;
    else       filtY <= filtY + delta;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            thrVal <= '1;
    else if (ctl.thrLoad) thrVal <= thrWrData;
  end

  assign aboveThr = filtY > signed'({1'b0, thrVal});
endmodule

// File: rtl/tri_trig_ctl.sv
module tri_trig_ctl
  import tri_trigger_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     thrWrEn,
  input  logic     aboveThr,
  output trigCtl_t ctl,
  output logic     trigOut
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic             armed;
  logic             fire;
  logic [CNT_W-1:0] pulseCnt;

  assign ctl.thrLoad = thrWrEn;
  assign fire        = armed && aboveThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b1;
      pulseCnt <= '0;
    end else begin
      // disarm while above, rearm once at or below
      armed <= !aboveThr;
      if (fire)                pulseCnt <= CNT_W'(PULSE_LEN);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - CNT_W'(1);
    end
  end

  assign trigOut = (pulseCnt != '0);
endmodule

// File: rtl/tri_trigger.sv
module tri_trigger
  import tri_trigger_pkg::*;
#(
  parameter  int SAMPLE_W  = 14,
  parameter  int MAX_K     = 64,
  parameter  int PULSE_LEN = 4,
  localparam int K_W       = $clog2(MAX_K + 1),
  localparam int ACC_W     = SAMPLE_W + $clog2(MAX_K) + 2,
  localparam int THR_W     = ACC_W - 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SAMPLE_W-1:0]     sampleIn,
  input  logic [K_W-1:0]          kSel,
  input  logic                    thrWrEn,
  input  logic [THR_W-1:0]        thrWrData,
  output logic signed [ACC_W-1:0] filterOut,
  output logic                    trigOut
);
  trigCtl_t         ctl;
  logic             aboveThr;
  logic [THR_W-1:0] thrQ;

  tri_filt_dp #(
    .SAMPLE_W(SAMPLE_W), .MAX_K(MAX_K), .K_W(K_W), .ACC_W(ACC_W), .THR_W(THR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .kSel(kSel),
    .thrWrData(thrWrData), .ctl(ctl), .filtY(filterOut),
    .thrVal(thrQ), .aboveThr(aboveThr)
  );

  tri_trig_ctl #(.PULSE_LEN(PULSE_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .thrWrEn(thrWrEn), .aboveThr(aboveThr),
    .ctl(ctl), .trigOut(trigOut)
  );
endmodule

// File: rtl/tri_trigger_chk.sv
module tri_trigger_chk #(
  parameter int SAMPLE_W  = 14,
  parameter int MAX_K     = 64,
  parameter int PULSE_LEN = 4,
  parameter int K_W       = 7,
  parameter int ACC_W     = 22,
  parameter int THR_W     = 21
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [SAMPLE_W-1:0]     sampleIn,
  input logic [K_W-1:0]          kSel,
  input logic                    thrWrEn,
  input logic [THR_W-1:0]        thrWrData,
  input logic signed [ACC_W-1:0] filterOut,
  input logic                    trigOut,
  input logic                    aboveThr,
  input logic [THR_W-1:0]        thrQ
);
  logic [SAMPLE_W-1:0] lastSample;
  int                  runLen;
  int                  highRun;
  longint              bnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSample <= '0;
      runLen     <= 0;
      highRun    <= 0;
    end else begin
      lastSample <= sampleIn;
      runLen     <= (sampleIn == lastSample) ? ((runLen < 2*MAX_K) ? runLen + 1 : runLen) : 1;
      highRun    <= trigOut ? ((highRun <= PULSE_LEN) ? highRun + 1 : highRun) : 0;
    end
  end

  assign bnd = longint'(kSel) * ((longint'(1) <<< SAMPLE_W) - 1);

  // R2
  flat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleIn == lastSample && runLen + 1 >= 2 * int'(kSel)) |=> (filterOut == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (longint'(filterOut) <= bnd) && (longint'(filterOut) >= -bnd));

  // R3
  fire_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> $past(aboveThr));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigOut) |-> (highRun >= PULSE_LEN));

  // R6
  thr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    thrWrEn |=> (thrQ == $past(thrWrData)));
endmodule

bind tri_trigger tri_trigger_chk #(
  .SAMPLE_W(SAMPLE_W), .MAX_K(MAX_K), .PULSE_LEN(PULSE_LEN),
  .K_W(K_W), .ACC_W(ACC_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .kSel(kSel),
  .thrWrEn(thrWrEn), .thrWrData(thrWrData), .filterOut(filterOut),
  .trigOut(trigOut), .aboveThr(aboveThr), .thrQ(thrQ)
);

// File: tb/test_tri_trigger.sv
module test_tri_trigger;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SW = 14;
  localparam int MK = 64;
  localparam int PL = 4;
  localparam int KW = $clog2(MK + 1);
  localparam int AW = SW + $clog2(MK) + 2;
  localparam int TW = AW - 1;
  localparam longint TMAX = (longint'(1) <<< TW) - 1;

  localparam int NV = 40;
  localparam int STIM [NV] = '{
    100, 100, 100, 100, 100, 100, 100, 100, 100, 100,
    400, 400, 400, 400, 400, 400,
    100, 100, 100, 100, 100, 100, 100, 100, 100, 100,
    1000,
    100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rstN;
  logic [SW-1:0]        sampleIn;
  logic [KW-1:0]        kSel;
  logic                 thrWrEn;
  logic [TW-1:0]        thrWrData;
  logic signed [AW-1:0] filterOut;
  logic                 trigOut;

  tri_trigger #(.SAMPLE_W(SW), .MAX_K(MK), .PULSE_LEN(PL)) i_tri_trigger (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .kSel(kSel),
    .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .filterOut(filterOut), .trigOut(trigOut)
  );

  int     nChk = 0;
  int     nBad = 0;
  bit     done = 1'b0;

  // reference model state
  int     hist [2*MK];
  int     mK;
  longint mThr;
  longint prevY;
  bit     mArm;
  int     mCnt;
  longint expY;
  bit     trigSeen;
  longint maxSeen;

  task automatic check(string tag, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(int k);
    rstN = 1'b0; kSel = KW'(k); sampleIn = '0; thrWrEn = 1'b0; thrWrData = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2*MK; i++) hist[i] = 0;
    mK = k; mThr = TMAX; prevY = 0; mArm = 1'b1; mCnt = 0; expY = 0;
    trigSeen = 1'b0; maxSeen = 0;
    rstN = 1'b1;
  endtask

  task automatic step(int x, bit wr, longint wd);
    bit fire;
    sampleIn = SW'(x); thrWrEn = wr; thrWrData = TW'(wd);
    @(posedge clk);
    fire = mArm && (prevY > mThr);
    if (fire) mCnt = PL;
    else if (mCnt > 0) mCnt--;
    mArm = !(prevY > mThr);
    if (wr) mThr = wd;
    for (int i = 2*MK-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    expY = 0;
    for (int j = 0; j < mK; j++) expY += hist[j];
    for (int j = mK; j < 2*mK; j++) expY -= hist[j];
    prevY = expY;
    @(negedge clk);
    check("R1", longint'(filterOut), expY);
    check("R3/R4/R5", longint'(trigOut), longint'(mCnt != 0));
    if (trigOut) trigSeen = 1'b1;
    if (longint'(filterOut) > maxSeen) maxSeen = longint'(filterOut);
    thrWrEn = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    rstN = 1'b0; kSel = KW'(4); sampleIn = SW'(9000); thrWrEn = 1'b0; thrWrData = '0;
    repeat (3) @(negedge clk);
    check("R9 filter", longint'(filterOut), 0);
    check("R9 trig", longint'(trigOut), 0);

    // R6: reset threshold is all ones, full-scale step never fires
    doReset(4);
    for (int i = 0; i < 12; i++) step(16383, 1'b0, 0);
    check("R6 no trig at reset thr", longint'(trigSeen), 0);

    // vector table walk: R1 R3 R4 R5 R6
    doReset(4);
    step(0, 1'b1, 300);
    for (int v = 0; v < NV; v++) step(STIM[v], 1'b0, 0);
    check("R5 fired during table", longint'(trigSeen), 1);

    // R2: flat offset cancels
    doReset(8);
    for (int i = 0; i < 20; i++) step(5000, 1'b0, 0);
    check("R2 flat zero", longint'(filterOut), 0);

    // R7: threshold 0, unit pulse fires
    doReset(4);
    step(0, 1'b1, 0);
    step(1, 1'b0, 0);
    for (int i = 0; i < 10; i++) step(0, 1'b0, 0);
    check("R7 unit fire", longint'(trigSeen), 1);

    // R8: full scale at maximum window
    doReset(MK);
    for (int i = 0; i < 2*MK + 8; i++) step(16383, 1'b0, 0);
    check("R8 peak", maxSeen, longint'(MK) * 16383);
    check("R8 settle", longint'(filterOut), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule